// File: doc/BRIEF.md
# Snapshot-and-Clear Group Cell Counter Bank

This block keeps one cell counter for each of sixteen receive groups and puts all of them behind a byte-wide host register port. Each group has a strobe input. One pulse on that input means one cell arrived, and the group's 16-bit counter advances by one. When the counter reaches its top value it stops there and does not roll over.

Each group has two views. In the live view the host reads the running counter. It reads the low byte first. That read captures the upper byte for the read that follows, and it restarts the count. A command write of 0x01 to the group's low-byte address freezes the current count into a holding register, clears the counter and switches to the snapshot view. In the snapshot view the host reads the frozen value, low byte first and then high byte, while counting continues out of sight. A command write of 0x00 goes back to the live view.

The register pairs are spread over four pages of 0x100 bytes each. Each page holds four groups.

Top module: `snapctr_bank`

## Requirements
- R1: After reset every counter, holding register and high-byte capture register is zero, every group is in the live view, and `bus_rdata` is 0x00.
- R2: Each cycle with a group's `cell_pulse` bit high adds one to that group's counter. Any set of groups may pulse in the same cycle, and each group counts independently of the others.
- R3: A counter at 0xFFFF stays at 0xFFFF when further pulses arrive.
- R4: Group g (0..15) has its low byte at address ((4 + g/4) << 8) | (0x50 + 2*(g mod 4)) and its high byte at that address plus 1. No other address is mapped.
- R5: Writing 0x01 to a group's low-byte address copies the counter into that group's holding register, clears the counter and selects the snapshot view.
- R6: In the snapshot view, reads of the low and high byte return bits 7:0 and 15:8 of the holding register. Cells counted after the snapshot do not change these reads.
- R7: If a cell pulse arrives in the same cycle as a snapshot command or a clearing live low-byte read, the cleared counter starts at 1. No cell is lost.
- R8: Writing 0x00 to a group's low-byte address selects the live view and leaves the counter unchanged.
- R9: In the live view, a low-byte read returns bits 7:0 of the counter, captures bits 15:8 into the group's high-byte capture register and clears the counter.
- R10: In the live view, a high-byte read returns the high-byte capture register. It does not return the live counter.
- R11: Writes to high-byte addresses, writes of any value other than 0x00 or 0x01, and writes to unmapped addresses have no effect. Reads of unmapped addresses return 0x00.
- R12: `bus_rdata` is registered. It shows the read result in the cycle after `bus_rd` is sampled high with `bus_wr` low, and it holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the counters and the register port |
| rst_n | input | 1 | Active-low synchronous reset |
| cell_pulse | input | 16 | One single-cycle cell strobe per group; bit g is group g |
| bus_addr | input | 12 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |

## Verification
The assertions take two things for granted. First, a cell strobe marks one cell per high cycle, in the counter's own clock. Second, a host access raises `bus_wr` or `bus_rd` but never both in the same cycle; the block gives such a cycle to the write and does not guarantee the read. The bench drives every strobe and access on the falling edge and keeps each access to a single cycle. It never asserts both bus strobes together. It sends long cell bursts as a strobe held high, which the block reads as one cell per cycle.

// File: rtl/snapctr_pkg.sv
package snapctr_pkg;

    localparam logic [7:0] CMD_SNAPSHOT = 8'h01;
    localparam logic [7:0] CMD_LIVE     = 8'h00;

    typedef struct packed {
        logic hit;
        logic is_hi;
    } dec_flags_t;

endpackage

// File: rtl/snapctr_decode.sv
module snapctr_decode #(
    parameter int ADDR_W        = 12,
    parameter int NUM_GROUPS    = 16,
    parameter int GRP_PER_PAGE  = 4,
    parameter int FIRST_PAGE    = 4,
    parameter int PAGE_OFF      = 'h50
) (
    input  logic [ADDR_W-1:0]             addr_i,
    output snapctr_pkg::dec_flags_t       flags_o,
    output logic [$clog2(NUM_GROUPS)-1:0] grp_o
);
    localparam int NUM_PAGES = NUM_GROUPS / GRP_PER_PAGE;
    localparam int PAGE_W    = ADDR_W - 8;
    localparam int SLOT_W    = $clog2(GRP_PER_PAGE);
    localparam int GIDX_W    = $clog2(NUM_GROUPS);
    localparam int SPAN      = 2 * GRP_PER_PAGE;

    logic [PAGE_W-1:0] page;
    logic [7:0]        offs;
    logic [7:0]        rel;
    int                page_rel;
    logic              in_page;
    logic              in_offs;

    always_comb begin
        page     = addr_i[ADDR_W-1:8];
        offs     = addr_i[7:0];
        rel      = offs - 8'(PAGE_OFF);
        page_rel = int'(page) - FIRST_PAGE;
        in_page  = (page_rel >= 0) && (page_rel < NUM_PAGES);
        in_offs  = (int'(offs) >= PAGE_OFF) && (int'(rel) < SPAN);
        flags_o.hit   = in_page && in_offs;
        flags_o.is_hi = rel[0];
        grp_o = flags_o.hit
              ? GIDX_W'(page_rel * GRP_PER_PAGE + int'(rel[SLOT_W:1]))
              : '0;
    end

endmodule

// File: rtl/snapctr_group.sv
module snapctr_group #(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cell_i,
    input  logic                snap_i,
    input  logic                live_i,
    input  logic                rdlo_i,
    output logic [2*DATA_W-1:0] cnt_o,
    output logic [2*DATA_W-1:0] hold_o,
    output logic [DATA_W-1:0]   shadow_o,
    output logic                snap_mode_o,
    output logic                clr_o
);
    localparam int CNT_W = 2 * DATA_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  hold;
        logic [DATA_W-1:0] shadow;
        logic              snap_mode;
    } grp_state_t;

    grp_state_t st_q, st_d;
    logic             clr;
    logic [CNT_W-1:0] base;

    always_comb begin
        st_d = st_q;
        clr  = snap_i || (rdlo_i && !st_q.snap_mode);
        base = clr ? '0 : st_q.cnt;
        if (cell_i && (base != CNT_MAX)) begin
            st_d.cnt = base + 1'b1;
        end else begin
            st_d.cnt = base;
        end
        if (snap_i) begin
            st_d.hold      = st_q.cnt;
            st_d.snap_mode = 1'b1;
        end else if (live_i) begin
            st_d.snap_mode = 1'b0;
        end
        if (rdlo_i && !st_q.snap_mode) begin
            st_d.shadow = st_q.cnt[CNT_W-1:DATA_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o       = st_q.cnt;
    assign hold_o      = st_q.hold;
    assign shadow_o    = st_q.shadow;
    assign snap_mode_o = st_q.snap_mode;
    assign clr_o       = clr;

endmodule

// File: rtl/snapctr_bank.sv
module snapctr_bank #(
    parameter int NUM_GROUPS   = 16,
    parameter int DATA_W       = 8,
    parameter int ADDR_W       = 12,
    parameter int GRP_PER_PAGE = 4,
    parameter int FIRST_PAGE   = 4,
    parameter int PAGE_OFF     = 'h50
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_GROUPS-1:0] cell_pulse,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata
);
    import snapctr_pkg::*;

    localparam int CNT_W  = 2 * DATA_W;
    localparam int GIDX_W = $clog2(NUM_GROUPS);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } port_state_t;

    dec_flags_t        dec;
    logic [GIDX_W-1:0] dec_grp;

    logic [NUM_GROUPS-1:0][CNT_W-1:0]  cnt_all;
    logic [NUM_GROUPS-1:0][CNT_W-1:0]  hold_all;
    logic [NUM_GROUPS-1:0][DATA_W-1:0] shad_all;
    logic [NUM_GROUPS-1:0]             mode_all;
    logic [NUM_GROUPS-1:0]             clr_all;
    logic [NUM_GROUPS-1:0]             snap_v;
    logic [NUM_GROUPS-1:0]             live_v;
    logic [NUM_GROUPS-1:0]             rdlo_v;

    logic              wr_lo;
    logic              rd_ok;
    logic [DATA_W-1:0] sel_byte;
    port_state_t       ps_q, ps_d;

    snapctr_decode #(
        .ADDR_W      (ADDR_W),
        .NUM_GROUPS  (NUM_GROUPS),
        .GRP_PER_PAGE(GRP_PER_PAGE),
        .FIRST_PAGE  (FIRST_PAGE),
        .PAGE_OFF    (PAGE_OFF)
    ) u_dec (
        .addr_i (bus_addr),
        .flags_o(dec),
        .grp_o  (dec_grp)
    );

    always_comb begin
        wr_lo = bus_wr && dec.hit && !dec.is_hi;
        rd_ok = bus_rd && !bus_wr;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            snap_v[g] = wr_lo && (dec_grp == GIDX_W'(g)) && (bus_wdata == CMD_SNAPSHOT);
            live_v[g] = wr_lo && (dec_grp == GIDX_W'(g)) && (bus_wdata == CMD_LIVE);
            rdlo_v[g] = rd_ok && dec.hit && !dec.is_hi && (dec_grp == GIDX_W'(g));
        end
    end

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        snapctr_group #(.DATA_W(DATA_W)) u_grp (
            .clk        (clk),
            .rst_n      (rst_n),
            .cell_i     (cell_pulse[g]),
            .snap_i     (snap_v[g]),
            .live_i     (live_v[g]),
            .rdlo_i     (rdlo_v[g]),
            .cnt_o      (cnt_all[g]),
            .hold_o     (hold_all[g]),
            .shadow_o   (shad_all[g]),
            .snap_mode_o(mode_all[g]),
            .clr_o      (clr_all[g])
        );
    end

    always_comb begin
        ps_d = ps_q;
        if (dec.is_hi) begin
            sel_byte = mode_all[dec_grp] ? hold_all[dec_grp][CNT_W-1:DATA_W]
                                         : shad_all[dec_grp];
        end else begin
            sel_byte = mode_all[dec_grp] ? hold_all[dec_grp][DATA_W-1:0]
                                         : cnt_all[dec_grp][DATA_W-1:0];
        end
        if (rd_ok) begin
            ps_d.rdata = dec.hit ? sel_byte : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_q <= '0;
        end else begin
            ps_q <= ps_d;
        end
    end

    assign bus_rdata = ps_q.rdata;

endmodule

// File: rtl/snapctr_bank_chk.sv
module snapctr_bank_chk #(
    parameter int NUM_GROUPS = 16,
    parameter int DATA_W     = 8
) (
    input logic                                 clk,
    input logic                                 rst_n,
    input logic [NUM_GROUPS-1:0]                cell_pulse,
    input logic                                 bus_wr,
    input logic                                 bus_rd,
    input logic                                 hit,
    input logic [DATA_W-1:0]                    bus_rdata,
    input logic [NUM_GROUPS-1:0][2*DATA_W-1:0]  cnt_all,
    input logic [NUM_GROUPS-1:0][2*DATA_W-1:0]  hold_all,
    input logic [NUM_GROUPS-1:0][DATA_W-1:0]    shad_all,
    input logic [NUM_GROUPS-1:0]                mode_all,
    input logic [NUM_GROUPS-1:0]                clr_all,
    input logic [NUM_GROUPS-1:0]                snap_v,
    input logic [NUM_GROUPS-1:0]                live_v,
    input logic [NUM_GROUPS-1:0]                rdlo_v
);
    localparam int CNT_W = 2 * DATA_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && !hit) |=> (bus_rdata == '0));

    a_r12_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && !bus_wr) |=> $stable(bus_rdata));

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
        a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_all[g] && cell_pulse[g] && cnt_all[g] != CNT_MAX)
            |=> (cnt_all[g] == CNT_W'($past(cnt_all[g]) + 1'b1)));

        a_r3_saturate: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_all[g] && cnt_all[g] == CNT_MAX) |=> (cnt_all[g] == CNT_MAX));

        a_r5_snap_capture: assert property (@(posedge clk) disable iff (!rst_n)
            snap_v[g] |=> (hold_all[g] == $past(cnt_all[g]) && mode_all[g]));

        a_r7_clear_with_cell: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_all[g] && cell_pulse[g]) |=> (cnt_all[g] == CNT_W'(1)));

        a_r7_clear_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_all[g] && !cell_pulse[g]) |=> (cnt_all[g] == '0));

        a_r8_live_view: assert property (@(posedge clk) disable iff (!rst_n)
            live_v[g] |=> !mode_all[g]);

        a_r9_hi_capture: assert property (@(posedge clk) disable iff (!rst_n)
            (rdlo_v[g] && !mode_all[g])
            |=> (shad_all[g] == $past(cnt_all[g][CNT_W-1:DATA_W])));
    end

endmodule

bind snapctr_bank snapctr_bank_chk #(
    .NUM_GROUPS(NUM_GROUPS),
    .DATA_W    (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cell_pulse(cell_pulse),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .hit       (dec.hit),
    .bus_rdata (bus_rdata),
    .cnt_all   (cnt_all),
    .hold_all  (hold_all),
    .shad_all  (shad_all),
    .mode_all  (mode_all),
    .clr_all   (clr_all),
    .snap_v    (snap_v),
    .live_v    (live_v),
    .rdlo_v    (rdlo_v)
);

// File: tb/tb_snapctr_bank.sv
`timescale 1ns/1ps
module tb_snapctr_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cell_pulse = '0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;

    int  n_tests = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    snapctr_bank dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cell_pulse(cell_pulse),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    typedef struct packed {
        logic [3:0]  grp;
        logic [16:0] npulse;
        logic [15:0] expv;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{grp: 4'd0,  npulse: 17'd3,   expv: 16'd3},
        '{grp: 4'd5,  npulse: 17'd1,   expv: 16'd1},
        '{grp: 4'd15, npulse: 17'd10,  expv: 16'd10},
        '{grp: 4'd7,  npulse: 17'd0,   expv: 16'd0},
        '{grp: 4'd0,  npulse: 17'd2,   expv: 16'd2},
        '{grp: 4'd12, npulse: 17'd300, expv: 16'd300},
        '{grp: 4'd3,  npulse: 17'd256, expv: 16'd256},
        '{grp: 4'd9,  npulse: 17'd255, expv: 16'd255}
    };

    function automatic logic [11:0] lo_addr(input int g);
        return 12'(((4 + g / 4) << 8) | (8'h50 + 2 * (g % 4)));
    endfunction

    task automatic check(input string req, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [15:0] mask, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cell_pulse = mask;
        end
        @(negedge clk);
        cell_pulse = '0;
    endtask

    task automatic read_pair(input int g, output logic [15:0] v);
        logic [7:0] lo, hi;
        bus_read(lo_addr(g), lo);
        bus_read(lo_addr(g) + 12'd1, hi);
        v = {hi, lo};
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  b;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rdata after reset", int'(bus_rdata), 0);
        read_pair(1, v);
        check("R1 counter zero after reset", int'(v), 0);

        // Vector table: pulse, snapshot, read pair, back to live view (R4, R5, R6, R8)
        for (int k = 0; k < NVEC; k++) begin
            if (VECS[k].npulse != 0) pulse(16'(1) << VECS[k].grp, int'(VECS[k].npulse));
            bus_write(lo_addr(int'(VECS[k].grp)), 8'h01);
            read_pair(int'(VECS[k].grp), v);
            check("R4/R5/R6 snapshot pair", int'(v), int'(VECS[k].expv));
            bus_write(lo_addr(int'(VECS[k].grp)), 8'h00);
            read_pair(int'(VECS[k].grp), v);
            check("R8 live view cleared after snapshot", int'(v), 0);
        end

        // R2: simultaneous groups
        pulse(16'h0006, 4);
        pulse(16'h0004, 1);
        read_pair(1, v);
        check("R2 group 1 concurrent count", int'(v), 4);
        read_pair(2, v);
        check("R2 group 2 independent count", int'(v), 5);
        read_pair(1, v);
        check("R9 live low read clears counter", int'(v), 0);

        // R9 + R7: clearing low read with a cell in the same cycle
        pulse(16'h0100, 6);
        @(negedge clk);
        bus_addr = lo_addr(8); bus_rd = 1'b1; cell_pulse = 16'h0100;
        @(negedge clk);
        bus_rd = 1'b0; cell_pulse = '0;
        check("R9 live low read returns count", int'(bus_rdata), 6);
        bus_read(lo_addr(8), b);
        check("R7 cell during clearing read kept", int'(b), 1);

        // R7: snapshot with a cell in the same cycle
        pulse(16'h0010, 5);
        @(negedge clk);
        bus_addr = lo_addr(4); bus_wdata = 8'h01; bus_wr = 1'b1; cell_pulse = 16'h0010;
        @(negedge clk);
        bus_wr = 1'b0; cell_pulse = '0;
        read_pair(4, v);
        check("R7 snapshot holds prior count", int'(v), 5);
        bus_write(lo_addr(4), 8'h00);
        bus_read(lo_addr(4), b);
        check("R7 new count starts at one", int'(b), 1);

        // R6: counting continues hidden in snapshot view
        pulse(16'h0040, 2);
        bus_write(lo_addr(6), 8'h01);
        pulse(16'h0040, 3);
        read_pair(6, v);
        check("R6 snapshot unaffected by new cells", int'(v), 2);
        bus_write(lo_addr(6), 8'h00);
        bus_read(lo_addr(6), b);
        check("R8 live view shows hidden count", int'(b), 3);

        // R3: saturation
        pulse(16'h0400, 65540);
        read_pair(10, v);
        check("R3 counter saturates", int'(v), 16'hFFFF);

        // R10: high read returns the captured byte, not the live one
        pulse(16'h0400, 300);
        bus_read(lo_addr(10) + 12'd1, b);
        check("R10 high read returns stale capture", int'(b), 8'hFF);
        read_pair(10, v);
        check("R10 coherent pair after low read", int'(v), 300);

        // R11: ignored writes
        pulse(16'h0800, 7);
        bus_write(lo_addr(11) + 12'd1, 8'h01);
        bus_write(lo_addr(11), 8'h02);
        bus_write(12'h458, 8'h01);
        pulse(16'h0800, 1);
        read_pair(11, v);
        check("R11 ignored writes leave live count", int'(v), 8);

        // R11 unmapped reads, R12 hold
        pulse(16'h2000, 9);
        bus_read(lo_addr(13), b);
        check("R12 read data", int'(b), 9);
        repeat (3) @(negedge clk);
        check("R12 rdata held between reads", int'(bus_rdata), 9);
        bus_read(12'h458, b);
        check("R11 unmapped read zero", int'(b), 0);
        bus_read(12'h350, b);
        check("R11 unmapped page read zero", int'(b), 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule